// File: doc/BRIEF.md
# Wide-Bus Single-Word Write Packer

This block moves a run of 32-bit result words from a local block RAM out to external memory over a 512-bit AXI4 write port. It reads one word at a time, places it in its own 32-bit lane of the wide data bus, and enables only that lane's four bytes in the write strobe. Every word is sent as a single-beat transaction: address, then data, then the write response. The block then moves on to the next word.

The lane a word uses comes from a small counter. The counter steps once per accepted write response and rolls over after sixteen words. Because of this, a word is never shifted past the top of the bus, however long the run is. Every sixteen words fill one 64-byte line, and the address moves up by 64 bytes at each rollover. A one-cycle start pulse loads a line-aligned base address and a word count. A one-cycle done pulse marks the end of the run. A sticky flag records any response that is not OKAY.

Top module: `axi_lane_packer`

## Requirements
- R1: Word k is written with AWADDR = base + 64*floor(k/16), AWLEN = 0, AWSIZE = 3'b110 (64 bytes) and AWBURST = 2'b01 (incrementing).
- R2: For word k, WDATA holds RAM word k in bits [32*(k mod 16) +: 32], all other bits are zero, and WLAST is 1.
- R3: For word k, WSTRB is 4'hF placed at bits [4*(k mod 16) +: 4], with every other strobe bit zero.
- R4: The lane index is k mod 16. It advances on each accepted write response and returns to 0 after lane 15, so runs of 16, 64 and 256 words put every word in memory.
- R5: Each word goes through an address handshake, then a data handshake, then a response handshake. BREADY is high only after the data handshake, and the next address is not offered before the response handshake.
- R6: Once AWVALID or WVALID is raised, it stays high and its payload stays unchanged until the matching ready is seen.
- R7: RAM word 0 is read right after start. Word k+1 is read exactly once, at address k+1, while the response of word k is awaited. No read is made past the last word. The RAM returns data one cycle after the read enable.
- R8: done_o is high for exactly one cycle, in the cycle after the final response handshake. A start with count 0 gives done_o in the cycle after start and makes no transactions.
- R9: err_o goes high after any response with BRESP != 2'b00, stays high until the next accepted start, and is cleared by that start.
- R10: A start pulse that arrives while a run is in progress is ignored. The run keeps its base address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, loads base and count when idle |
| base_addr_i | input | ADDR_W | Line-aligned byte address of word 0 |
| count_i | input | RAM_AW+1 | Number of words to write |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Sticky bad-response flag |
| ram_rd_en_o | output | 1 | Local RAM read enable |
| ram_rd_addr_o | output | RAM_AW | Local RAM read address |
| ram_rd_data_i | input | ELEM_W | Local RAM read data, one cycle after enable |
| awvalid_o | output | 1 | Write address valid |
| awready_i | input | 1 | Write address ready |
| awaddr_o | output | ADDR_W | Write address |
| awlen_o | output | 8 | Burst length minus one (always 0) |
| awsize_o | output | 3 | Beat size code (64 bytes) |
| awburst_o | output | 2 | Burst type (incrementing) |
| wvalid_o | output | 1 | Write data valid |
| wready_i | input | 1 | Write data ready |
| wdata_o | output | DATA_W | Lane-placed write data |
| wstrb_o | output | DATA_W/8 | Byte strobes for the active lane |
| wlast_o | output | 1 | Last beat (always 1) |
| bvalid_i | input | 1 | Write response valid |
| bready_o | output | 1 | Write response ready |
| bresp_i | input | 2 | Write response code |

## Verification
The bench keeps the 512-bit bus and 32-bit words, and builds the block with RAM_AW = 8. A 256-word run therefore uses the full RAM depth and ends on its last address. Runs of 16, 64 and 256 words cover one line, four lines and sixteen lane rollovers. With these counts the bench can compare every byte written to memory against the RAM contents and confirm that no zero-filled lane appears. A run with one error response, followed by a clean run, covers the sticky flag and its clearing. A zero-length run and a start pulse sent in the middle of a run cover the edge cases of the start logic.

// File: rtl/lane_packer_pkg.sv
// Shared types for the wide-bus write packer.
package lane_packer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ADDR,
        ST_DATA,
        ST_RESP,
        ST_DONE
    } pk_state_t;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/lane_index_counter.sv
// Lane index counter: steps once per accepted write response while the
// sequencer is in a write phase, rolls over naturally at 2**LANE_W, and is
// held at zero outside the write phases.
// Assumes beat_done_i is a single-cycle handshake indication.
module lane_index_counter #(
    parameter int LANE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_write_i,
    input  logic              beat_done_i,
    output logic [LANE_W-1:0] lane_o
);
    logic [LANE_W-1:0] lane_q;

    // Advance on response handshakes, clear outside the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n)           lane_q <= '0;
        else if (!in_write_i) lane_q <= '0;
        else if (beat_done_i) lane_q <= lane_q + LANE_W'(1);
    end

    assign lane_o = lane_q;

    // R4
    lane_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_write_i && beat_done_i && (lane_q == {LANE_W{1'b1}})) |=> (lane_q == '0));
endmodule

// File: rtl/lane_shifter.sv
// Lane placer: puts one element into the lane picked by lane_i and builds
// the matching byte strobe. Each lane is selected on its own, so no shift
// can carry the element past the top of the bus.
// Assumes DATA_W is a whole multiple of ELEM_W and ELEM_W of 8.
module lane_shifter #(
    parameter int ELEM_W = 32,
    parameter int DATA_W = 512,
    parameter int LANE_W = 4
) (
    input  logic [ELEM_W-1:0]   elem_i,
    input  logic [LANE_W-1:0]   lane_i,
    output logic [DATA_W-1:0]   wdata_o,
    output logic [DATA_W/8-1:0] wstrb_o
);
    localparam int LANES   = DATA_W / ELEM_W;
    localparam int EBYTES  = ELEM_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Drive this lane's data and strobes only when it is selected.
        always_comb begin
            wdata_o[g*ELEM_W +: ELEM_W] = (lane_i == LANE_W'(g)) ? elem_i : '0;
            wstrb_o[g*EBYTES +: EBYTES] = (lane_i == LANE_W'(g)) ? {EBYTES{1'b1}} : '0;
        end
    end
endmodule

// File: rtl/lane_packer_ctrl.sv
// Sequencer: fetches one RAM word at a time and steps through the address,
// data and response phases of a single-beat write per word. The next word is
// prefetched while the response is awaited.
// Assumes a RAM with one cycle of read latency and a line-aligned base.
module lane_packer_ctrl
    import lane_packer_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int RAM_AW  = 10,
    parameter int CNT_W   = 11,
    parameter int ELEM_W  = 32,
    parameter int LANE_W  = 4,
    parameter int BEAT_SH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              awready_i,
    input  logic              wready_i,
    input  logic              bvalid_i,
    input  logic [1:0]        bresp_i,
    input  logic [ELEM_W-1:0] ram_rd_data_i,
    output pk_state_t         state_o,
    output logic [CNT_W-1:0]  idx_o,
    output logic [ELEM_W-1:0] elem_o,
    output logic              awvalid_o,
    output logic [ADDR_W-1:0] awaddr_o,
    output logic              wvalid_o,
    output logic              bready_o,
    output logic              ram_rd_en_o,
    output logic [RAM_AW-1:0] ram_rd_addr_o,
    output logic              done_o,
    output logic              err_o
);
    pk_state_t         state_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q, idx_q;
    logic [ELEM_W-1:0] elem_q;
    logic              fetched_q, rd_pend_q, err_q;
    logic              is_last;
    logic [CNT_W-1:0]  nxt_idx;

    assign is_last = (idx_q == cnt_q - CNT_W'(1));
    assign nxt_idx = idx_q + CNT_W'(1);

    // Phase sequencing, run bookkeeping and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            base_q    <= '0;
            cnt_q     <= '0;
            idx_q     <= '0;
            fetched_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    base_q  <= base_addr_i;
                    cnt_q   <= count_i;
                    idx_q   <= '0;
                    err_q   <= 1'b0;
                    state_q <= (count_i == '0) ? ST_DONE : ST_FETCH;
                end
                ST_FETCH: state_q <= ST_ADDR;
                ST_ADDR:  if (awready_i) state_q <= ST_DATA;
                ST_DATA:  if (wready_i) begin
                    state_q   <= ST_RESP;
                    fetched_q <= 1'b0;
                end
                ST_RESP: begin
                    if (ram_rd_en_o) fetched_q <= 1'b1;
                    if (bvalid_i) begin
                        if (bresp_i != RESP_OKAY) err_q <= 1'b1;
                        if (is_last) state_q <= ST_DONE;
                        else begin
                            idx_q   <= nxt_idx;
                            state_q <= ST_ADDR;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture RAM data one cycle after each read enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            elem_q    <= '0;
        end else begin
            rd_pend_q <= ram_rd_en_o;
            if (rd_pend_q) elem_q <= ram_rd_data_i;
        end
    end

    // Decode handshake outputs and RAM reads from the current phase.
    always_comb begin
        awvalid_o     = (state_q == ST_ADDR);
        wvalid_o      = (state_q == ST_DATA);
        bready_o      = (state_q == ST_RESP);
        ram_rd_en_o   = (state_q == ST_FETCH) ||
                        ((state_q == ST_RESP) && !fetched_q && !is_last);
        ram_rd_addr_o = (state_q == ST_RESP) ? nxt_idx[RAM_AW-1:0] : idx_q[RAM_AW-1:0];
        awaddr_o      = base_q + (ADDR_W'(idx_q >> LANE_W) << BEAT_SH);
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;
    assign elem_o  = elem_q;
    assign done_o  = (state_q == ST_DONE);
    assign err_o   = err_q;

    // R6
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid_o && !awready_i) |=> (awvalid_o && $stable(awaddr_o)));
    // R6
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid_o && !wready_i) |=> (wvalid_o && $stable(elem_o)));
    // R5
    w_after_aw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wvalid_o) |-> $past(awvalid_o && awready_i));
    // R5
    aw_after_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(awvalid_o) && $past(bready_o)) |-> $past(bvalid_i));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(state_q == ST_IDLE && start_i)) |=> err_o);
endmodule

// File: rtl/axi_lane_packer.sv
// Top level: writes a run of narrow RAM words to a wide AXI4 write port, one
// single-beat transaction per word, each word placed in its own lane.
// Assumes base_addr_i is aligned to DATA_W/8 bytes and count_i <= 2**RAM_AW.
module axi_lane_packer
    import lane_packer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 512,
    parameter int ELEM_W = 32,
    parameter int RAM_AW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [ADDR_W-1:0]    base_addr_i,
    input  logic [RAM_AW:0]      count_i,
    output logic                 done_o,
    output logic                 err_o,
    output logic                 ram_rd_en_o,
    output logic [RAM_AW-1:0]    ram_rd_addr_o,
    input  logic [ELEM_W-1:0]    ram_rd_data_i,
    output logic                 awvalid_o,
    input  logic                 awready_i,
    output logic [ADDR_W-1:0]    awaddr_o,
    output logic [7:0]           awlen_o,
    output logic [2:0]           awsize_o,
    output logic [1:0]           awburst_o,
    output logic                 wvalid_o,
    input  logic                 wready_i,
    output logic [DATA_W-1:0]    wdata_o,
    output logic [DATA_W/8-1:0]  wstrb_o,
    output logic                 wlast_o,
    input  logic                 bvalid_i,
    output logic                 bready_o,
    input  logic [1:0]           bresp_i
);
    localparam int CNT_W   = RAM_AW + 1;
    localparam int LANES   = DATA_W / ELEM_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int BEAT_SH = $clog2(DATA_W / 8);

    pk_state_t         state;
    logic [CNT_W-1:0]  idx;
    logic [ELEM_W-1:0] elem;
    logic [LANE_W-1:0] lane;
    logic              in_write;

    lane_packer_ctrl #(
        .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .CNT_W(CNT_W),
        .ELEM_W(ELEM_W), .LANE_W(LANE_W), .BEAT_SH(BEAT_SH)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .base_addr_i(base_addr_i), .count_i(count_i),
        .awready_i(awready_i), .wready_i(wready_i),
        .bvalid_i(bvalid_i), .bresp_i(bresp_i),
        .ram_rd_data_i(ram_rd_data_i),
        .state_o(state), .idx_o(idx), .elem_o(elem),
        .awvalid_o(awvalid_o), .awaddr_o(awaddr_o),
        .wvalid_o(wvalid_o), .bready_o(bready_o),
        .ram_rd_en_o(ram_rd_en_o), .ram_rd_addr_o(ram_rd_addr_o),
        .done_o(done_o), .err_o(err_o)
    );

    assign in_write = (state == ST_ADDR) || (state == ST_DATA) || (state == ST_RESP);

    lane_index_counter #(.LANE_W(LANE_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .in_write_i(in_write),
        .beat_done_i(bvalid_i && bready_o), .lane_o(lane)
    );

    lane_shifter #(.ELEM_W(ELEM_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_shift (
        .elem_i(elem), .lane_i(lane), .wdata_o(wdata_o), .wstrb_o(wstrb_o)
    );

    assign awlen_o   = 8'd0;
    assign awsize_o  = 3'(BEAT_SH);
    assign awburst_o = BURST_INCR;
    assign wlast_o   = 1'b1;

    // R4
    lane_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_write |-> (lane == idx[LANE_W-1:0]));
    // R3
    strb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid_o |-> ($countones(wstrb_o) == ELEM_W / 8));
    // R6
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid_o && !wready_i) |=> ($stable(wdata_o) && $stable(wstrb_o)));
endmodule

// File: tb/axi_lane_packer_bench.sv
module axi_lane_packer_bench;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 512;
    localparam int ELEM_W = 32;
    localparam int RAM_AW = 8;
    localparam int CNT_W  = RAM_AW + 1;
    localparam int STRB_W = DATA_W / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [ADDR_W-1:0] base_addr_i = '0;
    logic [CNT_W-1:0]  count_i = '0;
    logic done_o, err_o, ram_rd_en_o;
    logic [RAM_AW-1:0] ram_rd_addr_o;
    logic [ELEM_W-1:0] ram_rd_data_i = '0;
    logic awvalid_o, awready_i = 1'b0;
    logic [ADDR_W-1:0] awaddr_o;
    logic [7:0] awlen_o;
    logic [2:0] awsize_o;
    logic [1:0] awburst_o;
    logic wvalid_o, wready_i = 1'b0;
    logic [DATA_W-1:0] wdata_o;
    logic [STRB_W-1:0] wstrb_o;
    logic wlast_o;
    logic bvalid_i = 1'b0, bready_o;
    logic [1:0] bresp_i = 2'b00;

    always #4 clk = ~clk;

    axi_lane_packer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ELEM_W(ELEM_W), .RAM_AW(RAM_AW))
    u_axi_lane_packer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .count_i(count_i), .done_o(done_o), .err_o(err_o),
        .ram_rd_en_o(ram_rd_en_o), .ram_rd_addr_o(ram_rd_addr_o), .ram_rd_data_i(ram_rd_data_i),
        .awvalid_o(awvalid_o), .awready_i(awready_i), .awaddr_o(awaddr_o),
        .awlen_o(awlen_o), .awsize_o(awsize_o), .awburst_o(awburst_o),
        .wvalid_o(wvalid_o), .wready_i(wready_i), .wdata_o(wdata_o), .wstrb_o(wstrb_o),
        .wlast_o(wlast_o), .bvalid_i(bvalid_i), .bready_o(bready_o), .bresp_i(bresp_i)
    );

    function automatic logic [ELEM_W-1:0] ram_val(int a);
        return {8'hC3, 8'(a), 16'(a * 37 + 5)};
    endfunction

    // RAM model with one cycle of read latency
    always @(posedge clk) if (ram_rd_en_o) ram_rd_data_i <= ram_val(int'(ram_rd_addr_o));

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] mem [longint];

    // reference state
    bit running = 0;
    int k_ref = 0, run_cnt = 0, bad_k = -1, rd_expect = 0, w_beats = 0;
    longint run_base = 0;
    bit aw_got = 0, b_armed = 0;
    int b_delay = 0;
    bit aw_fire_q = 0, w_fire_q = 0, b_fire_q = 0, b_err_q = 0, start_acc_q = 0, done_next = 0;
    bit done_exp = 0, err_exp = 0, run_done = 0;
    logic [ADDR_W-1:0] aw_addr_rec = '0;
    bit prev_awv = 0, prev_awr = 0, prev_wv = 0, prev_wr = 0;
    logic [ADDR_W-1:0] prev_awaddr = '0;
    logic [DATA_W-1:0] prev_wdata = '0;

    task automatic chk(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_now();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // One reference step per negedge: retire last edge, check, flag next edge
    task automatic step();
        logic [DATA_W-1:0] exp_d;
        logic [STRB_W-1:0] exp_s;
        bit aw_fire, w_fire, b_fire;
        // phase 1: consequences of handshakes completed at the last posedge
        if (aw_fire_q) aw_got = 1;
        if (b_fire_q) begin
            bvalid_i = 0;
            k_ref++;
            aw_got = 0;
        end
        if (w_fire_q) begin
            b_armed = 1;
            b_delay = cyc % 3;
        end
        if (b_armed) begin
            if (b_delay == 0) begin
                bvalid_i = 1;
                bresp_i  = (k_ref == bad_k) ? 2'b10 : 2'b00;
                b_armed  = 0;
            end else b_delay--;
        end
        done_exp = done_next;
        if (start_acc_q) err_exp = 0;
        if (b_fire_q && b_err_q) err_exp = 1;
        if (done_exp) run_done = 1;
        awready_i = (cyc % 3) != 1;
        wready_i  = (cyc % 4) != 2;

        // phase 2: compare outputs with the reference
        chk(done_o == done_exp, "R8 done", DATA_W'(done_o), DATA_W'(done_exp));
        chk(err_o == err_exp, "R9 err", DATA_W'(err_o), DATA_W'(err_exp));
        if (prev_awv && !prev_awr)
            chk(awvalid_o && awaddr_o == prev_awaddr, "R6 aw hold", DATA_W'(awaddr_o), DATA_W'(prev_awaddr));
        if (prev_wv && !prev_wr)
            chk(wvalid_o && wdata_o == prev_wdata, "R6 w hold", wdata_o, prev_wdata);
        if (awvalid_o) begin
            chk(!aw_got && running, "R5 aw order", DATA_W'(aw_got), 0);
            chk(awaddr_o == ADDR_W'(run_base + 64 * (k_ref / 16)), "R1 awaddr",
                DATA_W'(awaddr_o), DATA_W'(run_base + 64 * (k_ref / 16)));
            chk({awlen_o, awsize_o, awburst_o} == {8'd0, 3'b110, 2'b01}, "R1 aw fields",
                DATA_W'({awlen_o, awsize_o, awburst_o}), DATA_W'({8'd0, 3'b110, 2'b01}));
        end
        if (wvalid_o) begin
            exp_d = '0;
            exp_s = '0;
            exp_d[32 * (k_ref % 16) +: 32] = ram_val(k_ref);
            exp_s[4 * (k_ref % 16) +: 4] = 4'hF;
            chk(aw_got, "R5 w after aw", DATA_W'(aw_got), 1);
            chk(wdata_o == exp_d && wlast_o, "R2 wdata", wdata_o, exp_d);
            chk(wstrb_o == exp_s, "R3 wstrb", DATA_W'(wstrb_o), DATA_W'(exp_s));
        end
        if (bready_o) chk(aw_got && !awvalid_o && !wvalid_o, "R5 bready order", DATA_W'(bready_o), 0);
        if (ram_rd_en_o) begin
            chk(int'(ram_rd_addr_o) == rd_expect && rd_expect < run_cnt, "R7 ram read",
                DATA_W'(ram_rd_addr_o), DATA_W'(rd_expect));
            rd_expect++;
        end

        // phase 3: handshakes that complete at the next posedge
        aw_fire = awvalid_o && awready_i;
        w_fire  = wvalid_o && wready_i;
        b_fire  = bvalid_i && bready_o;
        if (aw_fire) aw_addr_rec = awaddr_o;
        if (w_fire) begin
            w_beats++;
            for (int i = 0; i < STRB_W; i++)
                if (wstrb_o[i]) mem[longint'(aw_addr_rec) + i] = wdata_o[8*i +: 8];
        end
        done_next = 0;
        start_acc_q = 0;
        if (b_fire && k_ref == run_cnt - 1) begin
            done_next = 1;
            running = 0;
        end
        if (start_i && !running && !done_exp) begin
            start_acc_q = 1;
            run_base = longint'(base_addr_i);
            run_cnt = int'(count_i);
            k_ref = 0;
            rd_expect = 0;
            aw_got = 0;
            running = (count_i != 0);
            done_next = (count_i == 0);
        end
        b_err_q = b_fire && (bresp_i != 2'b00);
        aw_fire_q = aw_fire;
        w_fire_q = w_fire;
        b_fire_q = b_fire;
        prev_awv = awvalid_o; prev_awr = awready_i; prev_awaddr = awaddr_o;
        prev_wv = wvalid_o; prev_wr = wready_i; prev_wdata = wdata_o;
        cyc++;
        if (cyc > 150000) begin
            chk(0, "watchdog", 0, 0);
            finish_now();
        end
    endtask

    task automatic cycle(bit st);
        @(negedge clk);
        start_i = st;
        step();
    endtask

    // Run one transfer; optionally pulse start again mid-run (R10)
    task automatic run(longint base, int cnt, int bad, bit restart);
        int t;
        bit hit;
        mem.delete();
        w_beats = 0;
        bad_k = bad;
        run_done = 0;
        @(negedge clk);
        base_addr_i = ADDR_W'(base);
        count_i = CNT_W'(cnt);
        start_i = 1;
        step();
        t = 0;
        while (!run_done && t < 5000) begin
            if (restart && t == 40) begin
                @(negedge clk);
                base_addr_i = 32'h7000_0000;
                count_i = CNT_W'(3);
                start_i = 1;
                step();
            end else cycle(0);
            t++;
        end
        chk(run_done, "R8 run finished", DATA_W'(run_done), 1);
        chk(w_beats == cnt, "R10 beat count", DATA_W'(w_beats), DATA_W'(cnt));
        chk(mem.num() == 4 * cnt, "R3 bytes written", DATA_W'(mem.num()), DATA_W'(4 * cnt));
        for (int k = 0; k < cnt; k++) begin
            logic [31:0] got;
            longint a;
            a = base + 64 * (k / 16) + 4 * (k % 16);
            hit = mem.exists(a) && mem.exists(a + 3);
            got = hit ? {mem[a+3], mem[a+2], mem[a+1], mem[a]} : 32'h0;
            chk(got == ram_val(k), "R4 memory image", DATA_W'(got), DATA_W'(ram_val(k)));
        end
        repeat (3) cycle(0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!awvalid_o && !wvalid_o && !bready_o && !done_o && !err_o && !ram_rd_en_o,
            "R8 reset state", DATA_W'({awvalid_o, wvalid_o, bready_o, done_o, err_o}), 0);
        rst_n = 1;
        repeat (2) cycle(0);
        run(64'h1000_0000, 16, -1, 0);     // 4x4
        run(64'h2000_0000, 64, -1, 0);     // 8x8
        run(64'h3000_0040, 256, -1, 1);    // 16x16, restart ignored
        run(64'h3800_0000, 0, -1, 0);      // empty run
        run(64'h4000_0000, 20, 3, 0);      // one error response
        chk(err_o, "R9 sticky after run", DATA_W'(err_o), 1);
        run(64'h5000_0000, 5, -1, 0);      // clean run clears flag
        chk(!err_o, "R9 cleared by start", DATA_W'(err_o), 0);
        finish_now();
    end
endmodule